// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM Generator

The block drives two pulse-width-modulated outputs from one shared timebase. The input clock first passes through a programmable prescaler and then through a fixed divide-by-two stage. The result steps an 8-bit counter that wraps after 254, so a full sweep covers 255 counts. Each output is high while the shared counter is greater than or equal to that channel's duty value. A larger duty value therefore gives a shorter high time. A duty value of zero holds the output high, and the all-ones value holds it low.

Software configures the block through a write-only register port with a single write strobe. It sets a prescale value, one duty value per channel, and a control byte. The control byte starts the timebase and enables each output on its own. A new duty value waits in a holding register and reaches the comparator only when the counter wraps, so a period is never cut short or doubled. A new prescale value is picked up each time the prescaler reaches its terminal count. Downstream, each output would usually feed an RC low-pass filter to make a DC level.

Top module: `dual_pwm_gen`

## Requirements
- R1: After synchronous reset the control, prescale and duty registers are zero and both outputs are low.
- R2: A write takes place on a clock edge with `wr_en` high. Address 0 is control (bit 0 run, bit 1 output A enable, bit 2 output B enable). Address 1 is prescale P, address 2 is duty A and address 3 is duty B.
- R3: While running, the counter advances once every 2·(P+1) clocks and steps through 0..254 before returning to 0. One PWM period is therefore 510·(P+1) clocks.
- R4: An output is high when the counter is at or above its active duty value D. This gives (255−D)·2·(P+1) high clocks per period for any D.
- R5: With D = 00h an enabled, running output is high in every cycle.
- R6: With D = FFh the output is low in every cycle.
- R7: With the run bit clear, both outputs are low and the prescaler, divider and counter are held at zero. After run is set, counting restarts from zero. With P = 0 and D = 1, the output first goes high on the third clock edge after the edge that writes the control register.
- R8: With its enable bit clear, a channel's output is low and the other channel is unaffected.
- R9: While running, a newly written duty value becomes active only at the counter wrap from 254 to 0. While stopped, it becomes active at once.
- R10: A new prescale value takes effect at the next prescaler terminal count. The period then settles to 510·(P_new+1) clocks.
- R11: The outputs are registered and follow the counter by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
Two functions can fall in the same cycle: a duty register write and the counter wrap that copies the held duty into the comparator. The bench first writes a new duty right after a wrap and confirms that the output keeps the old waveform for the rest of that period. It then issues random writes at arbitrary phases, some of which land on the wrap edge itself. Each case is judged by the exact count of high clocks over one full period, taken once the write has settled. Between wraps, the checker separately requires the active duty to hold steady.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRESC = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DUTY0 = 2'd2;

  typedef struct packed {
    logic en_b;
    logic en_a;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter int DUTY_W  = 8,
  parameter int PRESC_W = 8,
  parameter int NCH     = 2,
  parameter int DATA_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output ctrl_t                         ctrl,
  output logic [PRESC_W-1:0]            presc,
  output logic [NCH-1:0][DUTY_W-1:0]    duty
);
  localparam int CTRL_W = $bits(ctrl_t);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      presc <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CTRL)  ctrl  <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_addr == ADDR_PRESC) presc <= wr_data[PRESC_W-1:0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_duty
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_DUTY0 + ADDR_W'(i);
    always_ff @(posedge clk) begin
      if (rst)                               duty[i] <= '0;
      else if (wr_en && wr_addr == MY_ADDR)  duty[i] <= wr_data[DUTY_W-1:0];
    end
  end
endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
  parameter int PRESC_W = 8,
  parameter int CNT_W   = 8,
  parameter int MODULUS = 255
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc_in,
  output logic [CNT_W-1:0]   cnt,
  output logic               wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MODULUS - 1);

  logic [PRESC_W-1:0] pcnt;
  logic [PRESC_W-1:0] ps_act;
  logic               half;
  logic               term;

  assign term = (pcnt == ps_act);
  assign wrap = run && term && half && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt   <= '0;
      ps_act <= '0;
      half   <= 1'b0;
      cnt    <= '0;
    end else if (!run) begin
      pcnt   <= '0;
      ps_act <= presc_in;
      half   <= 1'b0;
      cnt    <= '0;
    end else if (term) begin
      pcnt   <= '0;
      ps_act <= presc_in;
      half   <= ~half;
      if (half) cnt <= (cnt == CNT_MAX) ? '0 : cnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              ch_en,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic [DUTY_W-1:0] cnt,
  output logic [DUTY_W-1:0] duty_act,
  output logic              pwm
);
  always_ff @(posedge clk) begin
    if (rst) begin
      duty_act <= '0;
      pwm      <= 1'b0;
    end else begin
      if (!run || wrap) duty_act <= duty_in;
      pwm <= run && ch_en && (cnt >= duty_act);
    end
  end
endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
  import dpwm_pkg::*;
#(
  parameter int DUTY_W  = 8,
  parameter int PRESC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic              pwm_a,
  output logic              pwm_b
);
  localparam int NCH     = 2;
  localparam int MODULUS = (1 << DUTY_W) - 1;

  ctrl_t                      ctrl;
  logic [PRESC_W-1:0]         presc;
  logic [NCH-1:0][DUTY_W-1:0] duty_reg;
  logic [NCH-1:0][DUTY_W-1:0] duty_act_v;
  logic [NCH-1:0]             en_v;
  logic [NCH-1:0]             pwm_v;
  logic [DUTY_W-1:0]          cnt;
  logic                       wrap;
  logic                       run;
  logic                       en_a;
  logic                       en_b;
  logic [DUTY_W-1:0]          duty_act_a;
  logic [DUTY_W-1:0]          duty_act_b;

  dpwm_regs #(
    .DUTY_W (DUTY_W),
    .PRESC_W(PRESC_W),
    .NCH    (NCH),
    .DATA_W (8)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .ctrl   (ctrl),
    .presc  (presc),
    .duty   (duty_reg)
  );

  assign run  = ctrl.run;
  assign en_a = ctrl.en_a;
  assign en_b = ctrl.en_b;
  assign en_v = {en_b, en_a};

  dpwm_timebase #(
    .PRESC_W(PRESC_W),
    .CNT_W  (DUTY_W),
    .MODULUS(MODULUS)
  ) u_tb (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .presc_in(presc),
    .cnt     (cnt),
    .wrap    (wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dpwm_channel #(.DUTY_W(DUTY_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .run     (run),
      .ch_en   (en_v[i]),
      .wrap    (wrap),
      .duty_in (duty_reg[i]),
      .cnt     (cnt),
      .duty_act(duty_act_v[i]),
      .pwm     (pwm_v[i])
    );
  end

  assign duty_act_a = duty_act_v[0];
  assign duty_act_b = duty_act_v[1];
  assign pwm_a      = pwm_v[0];
  assign pwm_b      = pwm_v[1];
endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker #(
  parameter int CNT_W   = 8,
  parameter int MODULUS = 255
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             en_a,
  input logic             en_b,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] duty_act_a,
  input logic [CNT_W-1:0] duty_act_b,
  input logic             pwm_a,
  input logic             pwm_b
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MODULUS - 1);

  a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);

  a_r3_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && (cnt != $past(cnt))) |->
      ((cnt == $past(cnt) + 1'b1) || (cnt == '0 && $past(cnt) == CNT_MAX)));

  a_r7_off_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!pwm_a && !pwm_b));

  a_r7_off_cnt: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));

  a_r8_a_off: assert property (@(posedge clk) disable iff (rst)
    !en_a |=> !pwm_a);

  a_r8_b_off: assert property (@(posedge clk) disable iff (rst)
    !en_b |=> !pwm_b);

  a_r9_hold_a: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> $stable(duty_act_a));

  a_r9_hold_b: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> $stable(duty_act_b));

  a_r5_full_a: assert property (@(posedge clk) disable iff (rst)
    (run && en_a && duty_act_a == '0) |=> pwm_a);

  a_r6_none_b: assert property (@(posedge clk) disable iff (rst)
    (duty_act_b == '1) |=> !pwm_b);
endmodule

bind dual_pwm_gen dpwm_checker #(
  .CNT_W  (DUTY_W),
  .MODULUS(MODULUS)
) u_dpwm_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .en_a      (en_a),
  .en_b      (en_b),
  .wrap      (wrap),
  .cnt       (cnt),
  .duty_act_a(duty_act_a),
  .duty_act_b(duty_act_b),
  .pwm_a     (pwm_a),
  .pwm_b     (pwm_b)
);

// File: tb/test_dual_pwm_gen.sv
`timescale 1ns/1ps
module test_dual_pwm_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_a;
  logic       pwm_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_pwm_gen i_dual_pwm_gen (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .pwm_a  (pwm_a),
    .pwm_b  (pwm_b)
  );

  function automatic int exp_high(int d, int p);
    return (255 - d) * 2 * (p + 1);
  endfunction

  function automatic int exp_period(int p);
    return 510 * (p + 1);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_high(int n, output int ha, output int hb);
    ha = 0; hb = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ha += int'(pwm_a);
      hb += int'(pwm_b);
    end
  endtask

  task automatic wait_cycles(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic rise_interval(output int len);
    logic prev;
    prev = pwm_a;
    while (!(pwm_a && !prev)) begin prev = pwm_a; @(negedge clk); end
    len = 0;
    prev = pwm_a;
    @(negedge clk); len++;
    while (!(pwm_a && !prev)) begin prev = pwm_a; @(negedge clk); len++; end
  endtask

  task automatic wait_fall_a();
    logic prev;
    prev = pwm_a;
    @(negedge clk);
    while (!(prev && !pwm_a)) begin prev = pwm_a; @(negedge clk); end
  endtask

  initial begin
    int ha, hb, len;
    int seed;
    seed = int'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state, outputs low
    check("R1 pwm_a after reset", int'(pwm_a), 0);
    check("R1 pwm_b after reset", int'(pwm_b), 0);
    // R1/R2: duty regs zero after reset; only enabling run+A shows constant high
    wr(2'd0, 8'h03);
    count_high(600, ha, hb);
    check("R1 reset duty zero gives full high A", ha, 600);
    check("R8 B disabled stays low", hb, 0);

    // R7: run cleared -> outputs low even with duty 0
    wr(2'd0, 8'h06);
    count_high(100, ha, hb);
    check("R7 stopped A low", ha, 0);
    check("R7 stopped B low", hb, 0);

    // R7 restart timing, R11 one-cycle output register
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h03);
    @(negedge clk); check("R7 restart edge1", int'(pwm_a), 0);
    @(negedge clk); check("R11 restart edge2", int'(pwm_a), 0);
    @(negedge clk); check("R7 restart edge3", int'(pwm_a), 1);

    // R5/R6 with both channels, P=1
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd1);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'hFF);
    wr(2'd0, 8'h07);
    wait_cycles(20);
    count_high(exp_period(1), ha, hb);
    check("R5 duty 00 full high", ha, exp_period(1));
    check("R6 duty FF never high", hb, 0);

    // R4 boundaries D=1 and D=254 at P=1 (written while stopped: R9 immediate)
    wr(2'd0, 8'h00);
    wr(2'd2, 8'd1);
    wr(2'd3, 8'd254);
    wr(2'd0, 8'h07);
    wait_cycles(30);
    count_high(exp_period(1), ha, hb);
    check("R4 duty 1", ha, exp_high(1, 1));
    check("R4 duty 254", hb, exp_high(254, 1));

    // R3 period with D=128, P=1
    wr(2'd2, 8'd128);
    rise_interval(len);
    rise_interval(len);
    check("R3 period P=1", len, exp_period(1));

    // R10 prescale change while running
    wr(2'd1, 8'd2);
    rise_interval(len);
    rise_interval(len);
    rise_interval(len);
    check("R10 period after prescale change", len, exp_period(2));

    // R9 buffered duty: P=0, duty A 200; write 10 right after a wrap
    wr(2'd1, 8'd0);
    wr(2'd2, 8'd200);
    wait_cycles(3 * exp_period(2));
    wait_fall_a();
    wr(2'd2, 8'd10);
    count_high(300, ha, hb);
    check("R9 old duty kept until wrap", ha, 0);
    wait_fall_a();
    count_high(exp_period(0), ha, hb);
    check("R9 new duty after wrap", ha, exp_high(10, 0));

    // R8: disable A only, B keeps running
    wr(2'd3, 8'd100);
    wr(2'd0, 8'h05);
    wait_cycles(2 * exp_period(0));
    count_high(exp_period(0), ha, hb);
    check("R8 A disabled low", ha, 0);
    check("R8 B unaffected", hb, exp_high(100, 0));

    // R4/R3/R2: random configurations
    wr(2'd0, 8'h07);
    for (int it = 0; it < 8; it++) begin
      int p, da, db;
      p  = int'($urandom % 4);
      da = int'($urandom % 256);
      db = int'($urandom % 256);
      if (it == 0) da = 0;
      if (it == 1) db = 255;
      wait_cycles(int'($urandom % 700));
      wr(2'd1, 8'(p));
      wr(2'd2, 8'(da));
      wr(2'd3, 8'(db));
      wait_cycles(4200);
      count_high(exp_period(p), ha, hb);
      check("R4 random A", ha, exp_high(da, p));
      check("R4 random B", hb, exp_high(db, p));
    end

    // R1: reset mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    count_high(50, ha, hb);
    check("R1 reset mid-run A", ha, 0);
    check("R1 reset mid-run B", hb, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule